// File: doc/BRIEF.md
# Serial Flash Boot-Streaming Controller

This block sits on the device side of a serial flash. After power-up or reset, the first chip-select cycle skips the command and address phases. The block waits a programmable number of serial clock cycles. It then streams bytes from a synchronous memory read port, starting at a 512-byte-aligned address. The bytes go out either one bit per clock on the single data output or four bits per clock on all four IO lines.

The boot settings are static inputs held elsewhere in non-volatile storage: an enable bit, a 23-bit start block number, an 8-bit wait count and a quad-mode bit. Once at least one complete byte has left the device and chip select rises, the block disarms until the next reset. A mode flag then tells the command decoder that normal command mode owns the bus. If chip select rises before the first byte is complete, the attempt is dropped and the block stays armed.

The block runs on the serial clock. Each rising edge with chip select low is one bus cycle. The memory returns data one clock after it sees an address with the read enable high.

Top module: `spi_bootstream`

## Requirements
- R1: With `cfg_enable` low, no cycle of chip select low ever enables an output, and `boot_mode` stays 0.
- R2: The first byte streamed after arming is read from byte address `{cfg_start, 9'b0}`.
- R3: Count the rising edges with `cs_n` low from 0. For edges 0 to `cfg_delay`-1 the output enables stay 0. The first bit or nibble is driven right after edge `cfg_delay`.
- R4: With `cfg_quad`=0, each byte goes out MSB first on `io_out[1]`, one bit per edge, with `io_oe`=4'b0010.
- R5: With `cfg_quad`=1, each byte takes two edges with `io_oe`=4'b1111. Bits 7..4 come first on `io_out[3:0]`, then bits 3..0.
- R6: Each following byte comes from the previous address plus one. The address wraps from all ones to zero.
- R7: The first byte counts as complete at edge `cfg_delay`+8 (serial) or `cfg_delay`+2 (quad). If chip select rises after that, the block disarms: `boot_mode` goes to 0, and later chip-select cycles enable no output until reset.
- R8: If chip select rises before the first byte is complete, the block stays armed. The next chip-select cycle restarts with the full wait from the start address.
- R9: While `cs_n` is high, `io_oe` is 0.
- R10: `boot_mode` is 1 exactly when `cfg_enable` is 1 and the block has not disarmed since reset. Reset rearms the block.
- R11: While a byte is being driven, `mem_rd_en` is 1 and `mem_addr` already holds the address of the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; rising edge samples `cs_n` |
| rst_n | input | 1 | Asynchronous active-low reset; rearms the block |
| cs_n | input | 1 | Chip select, active low |
| cfg_enable | input | 1 | Boot streaming enable setting |
| cfg_quad | input | 1 | 1 = four bits per clock, 0 = one bit per clock |
| cfg_start | input | ADDR_W-9 (23) | Start address in 512-byte blocks |
| cfg_delay | input | DLY_W (8) | Number of wait cycles before data |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | ADDR_W (32) | Memory byte address |
| mem_rdata | input | 8 | Memory data, valid one clock after the request |
| io_out | output | 4 | Data driven on IO3..IO0 |
| io_oe | output | 4 | Per-line output enable; 0 means high impedance |
| boot_mode | output | 1 | 1 = boot streaming owns the bus, 0 = command mode |

## Verification
The bench covers several corner cases:
- Zero wait, together with a chip select that rises again right away. A design that fetched the first byte late would stream a stale byte.
- The largest wait with a start block at the very top of memory. An off-by-one wait counter would shift every bit, and a missing wrap would read past the top.
- Chip select rising exactly one edge before the first byte completes, then exactly at completion. This separates an attempt that must rearm from one that must disarm.
- A disabled block, and repeat chip-select cycles after disarming. A design that rearmed itself would drive the bus a second time.

// File: rtl/spi_bootstream.sv
module spi_bootstream #(
  parameter int ADDR_W      = 32,
  parameter int DLY_W       = 8,
  parameter int BLOCK_SHIFT = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_n,
  input  logic                      cfg_enable,
  input  logic                      cfg_quad,
  input  logic [ADDR_W-BLOCK_SHIFT-1:0] cfg_start,
  input  logic [DLY_W-1:0]          cfg_delay,
  output logic                      mem_rd_en,
  output logic [ADDR_W-1:0]         mem_addr,
  input  logic [7:0]                mem_rdata,
  output logic [3:0]                io_out,
  output logic [3:0]                io_oe,
  output logic                      boot_mode
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic              busy_q, stream_q, first_q, done_q, quad_q;
  logic [DLY_W-1:0]  cnt_q;
  logic [2:0]        ph_q;
  logic [7:0]        sh_q;
  logic [ADDR_W-1:0] addr_q;

  wire [ADDR_W-1:0] start_addr = {cfg_start, {BLOCK_SHIFT{1'b0}}};
  wire armed   = cfg_enable & ~done_q;
  wire kick    = armed & ~busy_q & ~cs_n;
  wire last_ph = quad_q ? (ph_q == 3'd1) : (ph_q == 3'd7);
  wire load    = ~cs_n & ((kick & (cfg_delay == '0)) |
                          (busy_q & ~stream_q & (cnt_q == '0)) |
                          (busy_q & stream_q & last_ph));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      stream_q <= 1'b0;
      first_q  <= 1'b0;
      done_q   <= 1'b0;
      quad_q   <= 1'b0;
      cnt_q    <= '0;
      ph_q     <= '0;
      sh_q     <= '0;
      addr_q   <= '0;
    end else if (cs_n) begin
      if (busy_q && first_q) done_q <= 1'b1;
      busy_q   <= 1'b0;
      stream_q <= 1'b0;
      first_q  <= 1'b0;
    end else begin
      if (kick) begin
        busy_q <= 1'b1;
        quad_q <= cfg_quad;
        cnt_q  <= cfg_delay - 1'b1;
        addr_q <= start_addr;
      end
      if (load) begin
        sh_q     <= mem_rdata;
        ph_q     <= '0;
        stream_q <= 1'b1;
        addr_q   <= (busy_q ? addr_q : start_addr) + ONE;
        if (stream_q) first_q <= 1'b1;
      end else if (stream_q) begin
        sh_q <= quad_q ? {sh_q[3:0], 4'b0} : {sh_q[6:0], 1'b0};
        ph_q <= ph_q + 3'd1;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  wire driving = busy_q & stream_q & ~cs_n;

  assign io_oe     = driving ? (quad_q ? 4'b1111 : 4'b0010) : 4'b0000;
  assign io_out    = !driving ? 4'b0000 :
                     quad_q ? sh_q[7:4] : {2'b00, sh_q[7], 1'b0};
  assign mem_rd_en = armed;
  assign mem_addr  = (busy_q & ~cs_n) ? addr_q : start_addr;
  assign boot_mode = armed;

  AST_OFF_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && !busy_q) |=> !busy_q); // R1
  AST_NEXT_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cs_n || (mem_rd_en && mem_addr == $past(mem_addr) + ONE))); // R6
  AST_DISARM_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_q) && !busy_q && $past(first_q)) |-> done_q); // R7
  AST_DISARM_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q); // R7
  AST_EARLY_ABORT_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_q) && !busy_q && !$past(first_q)) |-> !done_q); // R8
endmodule

// File: tb/spi_bootstream_bench.sv
module spi_bootstream_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        cfg_enable = 1'b1;
  logic        cfg_quad = 1'b0;
  logic [22:0] cfg_start = '0;
  logic [7:0]  cfg_delay = '0;
  logic        mem_rd_en;
  logic [31:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic [3:0]  io_out, io_oe;
  logic        boot_mode;

  int vectors = 0;
  int misses  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_bootstream u_spi_bootstream (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cfg_enable(cfg_enable),
    .cfg_quad(cfg_quad), .cfg_start(cfg_start), .cfg_delay(cfg_delay),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .io_out(io_out), .io_oe(io_oe), .boot_mode(boot_mode));

  function automatic logic [7:0] pat(input logic [31:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'hA5;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rdata <= pat(mem_addr);

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  bit          m_active = 0, m_done = 0, m_quad = 0;
  int          m_n = 0, m_D = 0, m_L = 8;
  logic [31:0] m_base = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_done = 0;
    end else if (cs_n) begin
      if (m_active && m_n >= m_D + m_L) m_done = 1;
      m_active = 0;
    end else if (m_active) begin
      m_n++;
    end else if (cfg_enable && !m_done) begin
      m_active = 1; m_n = 0; m_D = int'(cfg_delay); m_quad = cfg_quad;
      m_L = cfg_quad ? 2 : 8; m_base = {cfg_start, 9'b0};
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    int k, idx;
    logic [31:0] a;
    logic [7:0]  b;
    int exp_oe;
    exp_oe = (m_active && !cs_n && m_n >= m_D) ? (m_quad ? 15 : 2) : 0;
    if (cs_n) chk("R9 oe with cs high", int'(io_oe), 0);
    else if (!cfg_enable) chk("R1 oe while disabled", int'(io_oe), 0);
    else if (m_done) chk("R7 oe after disarm", int'(io_oe), 0);
    else chk("R3 oe wait/stream timing", int'(io_oe), exp_oe);
    chk("R10 boot_mode", int'(boot_mode), int'(cfg_enable && !m_done));
    if (exp_oe != 0) begin
      k = m_n - m_D;
      idx = k / m_L;
      a = m_base + 32'(idx);
      b = pat(a);
      if (m_quad) begin
        if (idx == 0) chk("R5 R2 quad nibble first byte", int'(io_out), int'(k % 2 == 0 ? b[7:4] : b[3:0]));
        else if (a < m_base) chk("R5 R6 quad nibble wrapped", int'(io_out), int'(k % 2 == 0 ? b[7:4] : b[3:0]));
        else chk("R5 R6 quad nibble", int'(io_out), int'(k % 2 == 0 ? b[7:4] : b[3:0]));
      end else begin
        if (idx == 0) chk("R4 R2 serial bit first byte", int'(io_out[1]), int'(b[7 - (k % 8)]));
        else if (a < m_base) chk("R4 R6 serial bit wrapped", int'(io_out[1]), int'(b[7 - (k % 8)]));
        else chk("R4 R6 serial bit", int'(io_out[1]), int'(b[7 - (k % 8)]));
      end
      chk("R11 prefetch enable", int'(mem_rd_en), 1);
      chk("R11 prefetch address", int'(mem_addr), int'(a + 32'd1));
    end
  end

  task automatic do_reset();
    @(posedge clk); #2 rst_n = 1'b0; cs_n = 1'b1;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  task automatic cs_cycle(input int low_edges);
    @(posedge clk); #2 cs_n = 1'b0;
    repeat (low_edges) @(posedge clk);
    #2 cs_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #1;
    chk("R9 reset oe", int'(io_oe), 0);
    do_reset();
    @(negedge clk);
    chk("R10 reset boot_mode armed", int'(boot_mode), 1);

    cfg_quad = 0; cfg_delay = 8'd3; cfg_start = 23'd5;
    cs_cycle(3 + 8 * 4);
    @(negedge clk);
    chk("R7 disarmed after serial boot", int'(boot_mode), 0);
    cs_cycle(20);

    do_reset();
    cfg_quad = 1; cfg_delay = 8'd0; cfg_start = 23'h1234;
    cs_cycle(1);
    @(negedge clk);
    chk("R8 still armed after early abort", int'(boot_mode), 1);
    cs_cycle(40);
    @(negedge clk);
    chk("R7 disarmed after quad boot", int'(boot_mode), 0);

    do_reset();
    cfg_enable = 0;
    cs_cycle(30);
    @(negedge clk);
    chk("R1 disabled boot_mode", int'(boot_mode), 0);
    cfg_enable = 1;

    do_reset();
    cfg_quad = 0; cfg_delay = 8'd255; cfg_start = 23'h7FFFFF;
    cs_cycle(255 + 8 * 516);

    do_reset();
    cfg_quad = 1; cfg_delay = 8'd1; cfg_start = 23'd7;
    cs_cycle(3);
    @(negedge clk);
    chk("R8 abort one edge short stays armed", int'(boot_mode), 1);
    cs_cycle(4);
    @(negedge clk);
    chk("R7 disarm at exact completion", int'(boot_mode), 0);
    cs_cycle(10);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule